// File: doc/BRIEF.md
# Stacked SDRAM Bank Address Decoder

This block turns a flat physical byte address into a choice of one of four SDRAM banks and a byte offset inside that bank. Each bank has a size and an enable bit held in a small configuration store. The enabled banks are stacked from address zero upward in bank-index order with no holes. A bank's base is therefore the sum of the enabled sizes below it, and the block works that base out in hardware rather than taking it from software.

Bank sizes run from 16 MB to 128 MB in powers of two, so four full banks fill a 512 MB space. A configuration write causes one cycle of recomputation. While that happens, `busy` is high and lookups are refused. A lookup that is accepted gives a registered result one cycle later. An address past the top of the populated space is reported as a miss and selects no bank.

Top module: `sdram_bank_map`

## Requirements
- R1: After reset, `busy` and `res_valid` are 0 and every bank is disabled, so every lookup is a miss.
- R2: A cycle with `cfg_we` high stores `cfg_en` and `cfg_size` for bank `cfg_bank`. Size code c in 0..3 means 16 MB << c. Codes 4 to 7 are taken as 128 MB.
- R3: `busy` is 1 in the cycle after every cycle with `cfg_we` high, and 0 otherwise. Once `busy` has fallen, lookups use the new layout.
- R4: A lookup presented while `busy` is 1 is refused: `res_valid` stays 0 in the following cycle.
- R5: A lookup presented while `busy` is 0 gives `res_valid` = 1 in exactly the next cycle. It is 0 in that cycle if no lookup was accepted.
- R6: The base of each enabled bank is the sum of the sizes of the enabled banks with a lower index. `res_sel` bit i is set alone when base(i) <= address < base(i) + size(i).
- R7: On a hit, `res_offset` equals the address minus the base of the selected bank.
- R8: An address at or above the sum of all enabled sizes sets `res_miss`, with `res_sel` = 0 and `res_offset` = 0.
- R9: A disabled bank takes up no space and is never selected. The banks above it move down to close the gap.
- R10: `res_sel`, `res_offset` and `res_miss` hold their last values in every cycle where `res_valid` is 0.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | 2 | Bank index to write |
| cfg_en | input | 1 | Enable bit for that bank |
| cfg_size | input | 3 | Size code for that bank |
| busy | output | 1 | Base recomputation in progress; lookups refused |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 29 | Byte address to decode |
| res_valid | output | 1 | Result valid, one cycle after an accepted lookup |
| res_sel | output | 4 | One-hot bank select, all zero on a miss |
| res_offset | output | 29 | Byte offset inside the selected bank |
| res_miss | output | 1 | Address beyond the populated space |

## Verification
The bench sends addresses one below, exactly at, and one above every bank boundary and the top of the space. A design with a bound off by one would pick a neighbouring bank there, or miss the wrong final byte. The layouts tested include a disabled bank in the middle, size codes above 3, and a full 512 MB stack. A design that leaves a hole for a disabled bank, or that overflows the sum, would place later banks wrongly or report false misses. A lookup sent in the busy cycle checks that a design does not answer from half-updated bases.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  localparam int unsigned SDB_CODE_W = 3;

  typedef struct packed {
    logic                  en;
    logic [SDB_CODE_W-1:0] code;
  } bank_cfg_t;
endpackage

// File: rtl/sdb_cfg_regs.sv
module sdb_cfg_regs
  import sdb_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned BIDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [BIDX_W-1:0] bank_i,
  input  logic             en_i,
  input  logic [SDB_CODE_W-1:0] code_i,
  output bank_cfg_t        cfg_o [NUM_BANKS]
);
  bank_cfg_t cfg_q [NUM_BANKS];
  bank_cfg_t cfg_d [NUM_BANKS];

  always_comb begin
    for (int i = 0; i < NUM_BANKS; i++) begin
      cfg_d[i] = cfg_q[i];
      if (we_i && (int'(bank_i) == i)) begin
        cfg_d[i].en   = en_i;
        cfg_d[i].code = code_i;
      end
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[g] <= '0;
      end else if (we_i) begin
        cfg_q[g] <= cfg_d[g];
      end
    end
    assign cfg_o[g] = cfg_q[g];
  end

  // R2: the written bank holds the written value one cycle later
  assert_cfg_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && (int'(bank_i) < NUM_BANKS)) |=>
      (cfg_q[$past(bank_i)].en == $past(en_i)) && (cfg_q[$past(bank_i)].code == $past(code_i)));
endmodule

// File: rtl/sdb_base_calc.sv
module sdb_base_calc
  import sdb_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 29,
  parameter int unsigned MIN_SHIFT = 24,
  parameter int unsigned MAX_CODE  = 3,
  localparam int unsigned SUM_W    = ADDR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  bank_cfg_t        cfg_i   [NUM_BANKS],
  output logic             busy_o,
  output logic [SUM_W-1:0] bound_o [NUM_BANKS+1]
);
  logic             busy_q, busy_d;
  logic [SUM_W-1:0] size_c  [NUM_BANKS];
  logic [SUM_W-1:0] bound_d [NUM_BANKS+1];
  logic [SUM_W-1:0] bound_q [NUM_BANKS+1];

  always_comb begin
    for (int i = 0; i < NUM_BANKS; i++) begin
      int unsigned eff;
      eff = (int'(cfg_i[i].code) > int'(MAX_CODE)) ? MAX_CODE : int'(cfg_i[i].code);
      size_c[i] = cfg_i[i].en ? (SUM_W'(1) << (MIN_SHIFT + eff)) : '0;
    end
  end

  always_comb begin
    bound_d[0] = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      bound_d[i+1] = bound_d[i] + size_c[i];
    end
  end

  always_comb begin
    busy_d = we_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
    end
  end

  for (genvar g = 0; g <= NUM_BANKS; g++) begin : g_bound
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bound_q[g] <= '0;
      end else if (busy_q) begin
        bound_q[g] <= bound_d[g];
      end
    end
    assign bound_o[g] = bound_q[g];
  end

  assign busy_o = busy_q;

  // R6: the stacked bounds never decrease from one bank to the next
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_chk
    assert_bounds_ordered_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bound_q[g+1] >= bound_q[g]);
  end

  // R2: the total never runs past the address space
  assert_total_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bound_q[NUM_BANKS] <= (SUM_W'(1) << ADDR_W));

  // R3: bounds change only in the cycle following a busy cycle
  assert_bounds_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> $stable(bound_q[NUM_BANKS]));
endmodule

// File: rtl/sdb_lookup.sv
module sdb_lookup #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 29,
  localparam int unsigned SUM_W    = ADDR_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [SUM_W-1:0]     bound_i [NUM_BANKS+1],
  output logic                 valid_o,
  output logic [NUM_BANKS-1:0] sel_o,
  output logic [ADDR_W-1:0]    offset_o,
  output logic                 miss_o
);
  logic [SUM_W-1:0]     addr_ext;
  logic [NUM_BANKS-1:0] hit_c;
  logic [ADDR_W-1:0]    base_c;
  logic [ADDR_W-1:0]    offset_c;
  logic                 miss_c;

  logic                 valid_q, valid_d;
  logic [NUM_BANKS-1:0] sel_q, sel_d;
  logic [ADDR_W-1:0]    offset_q, offset_d;
  logic                 miss_q, miss_d;

  assign addr_ext = {1'b0, addr_i};

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_hit
    assign hit_c[g] = (addr_ext >= bound_i[g]) && (addr_ext < bound_i[g+1]);
  end

  always_comb begin
    base_c = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (hit_c[i]) base_c = base_c | bound_i[i][ADDR_W-1:0];
    end
    miss_c   = ~|hit_c;
    offset_c = miss_c ? '0 : (addr_i - base_c);
  end

  always_comb begin
    valid_d  = accept_i;
    sel_d    = sel_q;
    offset_d = offset_q;
    miss_d   = miss_q;
    if (accept_i) begin
      sel_d    = hit_c;
      offset_d = offset_c;
      miss_d   = miss_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      sel_q    <= '0;
      offset_q <= '0;
      miss_q   <= 1'b0;
    end else begin
      valid_q  <= valid_d;
      if (accept_i) begin
        sel_q    <= sel_d;
        offset_q <= offset_d;
        miss_q   <= miss_d;
      end
    end
  end

  assign valid_o  = valid_q;
  assign sel_o    = sel_q;
  assign offset_o = offset_q;
  assign miss_o   = miss_q;

  // R6: never more than one bank selected
  assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $onehot0(sel_q));

  // R8: a miss selects nothing and reports no offset; a hit selects exactly one bank
  assert_miss_nosel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (miss_q ? (sel_q == '0 && offset_q == '0) : ($countones(sel_q) == 1)));

  // R10: results hold while no new one is presented
  assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> ($stable(sel_q) && $stable(offset_q) && $stable(miss_q)));
endmodule

// File: rtl/sdram_bank_map.sv
module sdram_bank_map
  import sdb_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 29,
  parameter int unsigned MIN_SHIFT = 24,
  parameter int unsigned MAX_CODE  = 3,
  localparam int unsigned BIDX_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned SUM_W    = ADDR_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [BIDX_W-1:0]     cfg_bank,
  input  logic                  cfg_en,
  input  logic [SDB_CODE_W-1:0] cfg_size,
  output logic                  busy,
  input  logic                  lk_valid,
  input  logic [ADDR_W-1:0]     lk_addr,
  output logic                  res_valid,
  output logic [NUM_BANKS-1:0]  res_sel,
  output logic [ADDR_W-1:0]     res_offset,
  output logic                  res_miss
);
  bank_cfg_t        cfg_w   [NUM_BANKS];
  logic [SUM_W-1:0] bound_w [NUM_BANKS+1];
  logic             busy_w;
  logic             accept_w;

  sdb_cfg_regs #(.NUM_BANKS(NUM_BANKS)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (cfg_we),
    .bank_i (cfg_bank),
    .en_i   (cfg_en),
    .code_i (cfg_size),
    .cfg_o  (cfg_w)
  );

  sdb_base_calc #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .MIN_SHIFT (MIN_SHIFT),
    .MAX_CODE  (MAX_CODE)
  ) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (cfg_we),
    .cfg_i   (cfg_w),
    .busy_o  (busy_w),
    .bound_o (bound_w)
  );

  assign accept_w = lk_valid & ~busy_w;

  sdb_lookup #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_look (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept_w),
    .addr_i   (lk_addr),
    .bound_i  (bound_w),
    .valid_o  (res_valid),
    .sel_o    (res_sel),
    .offset_o (res_offset),
    .miss_o   (res_miss)
  );

  assign busy = busy_w;

  // R3: a write is followed by a busy cycle, and busy only follows a write
  assert_busy_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> busy);
  assert_busy_only_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $past(cfg_we));

  // R4: a lookup during busy produces no result
  assert_no_accept_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lk_valid) |=> !res_valid);

  // R5: every result answers a lookup one cycle earlier
  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($past(lk_valid) && !$past(busy)));
endmodule

// File: tb/sdram_bank_map_test.sv
`timescale 1ns/1ps
module sdram_bank_map_test;
  localparam int NB = 4;
  localparam int AW = 29;

  logic          clk, rst_n;
  logic          cfg_we, cfg_en;
  logic [1:0]    cfg_bank;
  logic [2:0]    cfg_size;
  logic          busy;
  logic          lk_valid;
  logic [AW-1:0] lk_addr;
  logic          res_valid, res_miss;
  logic [NB-1:0] res_sel;
  logic [AW-1:0] res_offset;

  int n_chk, n_bad;
  bit done;
  bit    m_en   [NB];
  int    m_code [NB];

  sdram_bank_map uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
    .cfg_en(cfg_en), .cfg_size(cfg_size), .busy(busy), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .res_valid(res_valid), .res_sel(res_sel),
    .res_offset(res_offset), .res_miss(res_miss)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint bsize(input int i);
    int c;
    if (!m_en[i]) return 0;
    c = (m_code[i] > 3) ? 3 : m_code[i];
    return longint'(64'd16777216) << c;
  endfunction

  function automatic longint bbase(input int i);
    longint s = 0;
    for (int k = 0; k < i; k++) s += bsize(k);
    return s;
  endfunction

  task automatic write_cfg(input int b, input bit en, input int code, input bit probe);
    cfg_we = 1'b1; cfg_bank = 2'(b); cfg_en = en; cfg_size = 3'(code);
    m_en[b] = en; m_code[b] = code;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R3 busy after write", longint'(busy), 1);
    if (probe) begin lk_valid = 1'b1; lk_addr = '0; end
    @(negedge clk);
    chk("R3 busy drops", longint'(busy), 0);
    if (probe) begin
      chk("R4 lookup refused while busy", longint'(res_valid), 0);
      lk_valid = 1'b0;
    end
  endtask

  task automatic lookup(input longint a);
    longint tot, off;
    int bk;
    logic [NB-1:0] en_mask;
    logic [NB-1:0] prev_sel;
    logic [AW-1:0] prev_off;
    lk_valid = 1'b1; lk_addr = AW'(a);
    @(negedge clk);
    lk_valid = 1'b0;
    tot = bbase(NB);
    bk = -1; off = 0;
    for (int i = 0; i < NB; i++)
      if (a >= bbase(i) && a < bbase(i) + bsize(i)) begin bk = i; off = a - bbase(i); end
    en_mask = '0;
    for (int i = 0; i < NB; i++) en_mask[i] = m_en[i];
    chk("R5 result valid next cycle", longint'(res_valid), 1);
    if (a >= tot) begin
      chk("R8 miss flag", longint'(res_miss), 1);
      chk("R8 no select on miss", longint'(res_sel), 0);
      chk("R8 zero offset on miss", longint'(res_offset), 0);
    end else begin
      chk("R6 bank select", longint'(res_sel), longint'(1) << bk);
      chk("R7 offset", longint'(res_offset), off);
      chk("R6 no miss", longint'(res_miss), 0);
    end
    if (en_mask != '1)
      chk("R9 disabled bank unselected", longint'(res_sel & ~en_mask), 0);
    prev_sel = res_sel; prev_off = res_offset;
    @(negedge clk);
    chk("R5 no result without lookup", longint'(res_valid), 0);
    chk("R10 select held", longint'(res_sel), longint'(prev_sel));
    chk("R10 offset held", longint'(res_offset), longint'(prev_off));
  endtask

  task automatic edges();
    for (int i = 0; i <= NB; i++) begin
      longint b = bbase(i);
      if (b > 0) lookup(b - 1);
      if (b < (longint'(1) << AW)) lookup(b);
      if (b + 1 < (longint'(1) << AW)) lookup(b + 1);
    end
  endtask

  initial begin
    int seed;
    n_chk = 0; n_bad = 0; done = 0;
    cfg_we = 0; cfg_en = 0; cfg_bank = 0; cfg_size = 0; lk_valid = 0; lk_addr = '0;
    for (int i = 0; i < NB; i++) begin m_en[i] = 0; m_code[i] = 0; end
    seed = $urandom(32'h5EED_0042);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 busy after reset", longint'(busy), 0);
    chk("R1 valid after reset", longint'(res_valid), 0);
    lookup(0);
    lookup(29'h123_4567);

    // R2/R6: four 16 MB banks
    for (int i = 0; i < NB; i++) write_cfg(i, 1, 0, i == 0);
    edges();
    // mixed 128/16/64/32
    write_cfg(0, 1, 3, 1); write_cfg(1, 1, 0, 0); write_cfg(2, 1, 2, 0); write_cfg(3, 1, 1, 0);
    edges();
    // R9: bank 1 disabled in the middle
    write_cfg(1, 0, 2, 1);
    edges();
    // R2: code above 3 acts as 128 MB; full stack of 512 MB
    write_cfg(1, 1, 6, 0); write_cfg(0, 1, 7, 0); write_cfg(2, 1, 3, 0); write_cfg(3, 1, 5, 0);
    edges();
    lookup((longint'(1) << AW) - 1);

    // constrained random layouts
    for (int r = 0; r < 40; r++) begin
      for (int i = 0; i < NB; i++)
        write_cfg(i, ($urandom % 5) != 0, $urandom % 8, ($urandom % 4) == 0);
      for (int k = 0; k < 20; k++) begin
        longint a;
        if ($urandom % 2) begin
          a = bbase($urandom % (NB + 1)) + longint'($urandom % 3) - 1;
          if (a < 0) a = 0;
          if (a >= (longint'(1) << AW)) a = (longint'(1) << AW) - 1;
        end else begin
          a = longint'($urandom % (32'd1 << AW));
        end
        lookup(a);
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule